// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the memory-mapped register side of a simple serial port. A 32-bit word bus writes and reads a set of registers: a control word of one-shot commands, a mode word, a baud divisor, an interrupt mask, a status word, and one holding register for each direction. The block turns these accesses into enable levels and reset pulses for the serial channel. It also exchanges bytes with the channel through a small handshake, latches the error conditions the channel reports, and drives one level-sensitive interrupt.

The serial framing logic, the baud generator and any DMA engine are outside the block. They connect to the channel-side ports. Software selects interrupt sources through a set-only port and a clear-only port and reads the resulting mask at its own address. Error flags stay set until software issues a control command that clears them.

Top module: `sercom_regs`

## Requirements
- R1: After a synchronous active-low reset: receiver and transmitter are disabled, the mask is 0, the interrupt is low, and status bit 1 (transmit ready) is set. Status bit 9 (transmitter empty) is set if `ch_tx_idle` is high. All other status bits are 0.
- R2: Writing the control word at 0x00 works as follows. Bit 4 enables the receiver and bit 5 disables it. Bit 6 enables the transmitter and bit 7 disables it. When the enable bit and the disable bit of one direction are both 1 in the same write, that direction ends up disabled.
- R3: Control bit 2 pulses `rx_reset`, disables the receiver and clears receive ready. Control bit 3 pulses `tx_reset`, disables the transmitter and drops any byte waiting in the transmit holding register.
- R4: A write to 0x08 sets the mask bits where the data has 1s, limited to the assigned set 0xC0001AFB. A write to 0x0C clears the mask bits where the data has 1s. The mask reads back at 0x10, and writes to 0x10 are ignored.
- R5: `irq` is high exactly when some status bit and the same mask bit are both 1.
- R6: A byte from the channel (`ch_rx_valid`) is stored only while the receiver is enabled. It sets receive ready (status bit 0). A read of 0x18 returns the byte in bits 7:0 and clears receive ready.
- R7: A byte that arrives while receive ready is still set sets overrun (status bit 5) and replaces the held byte.
- R8: A byte that arrives with a framing error sets status bit 6. A byte that arrives with a parity error sets status bit 7. Control bit 8 clears bits 5, 6 and 7 together.
- R9: A write to 0x1C holds the byte and clears transmit ready (status bit 1). The byte is offered on `ch_tx_data` with `ch_tx_valid` while the transmitter is enabled. A `ch_tx_take` pulse during `ch_tx_valid` sets transmit ready again.
- R10: Status bit 9 (transmitter empty) is 1 when no byte is waiting and `ch_tx_idle` is high.
- R11: Mode (0x04) and divisor (0x20) read back the written value, truncated to their widths. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| ch_rx_valid | input | 1 | Channel delivers a received byte |
| ch_rx_data | input | CHAR_W | Received byte |
| ch_rx_frame_err | input | 1 | Delivered byte had a framing error |
| ch_rx_parity_err | input | 1 | Delivered byte had a parity error |
| ch_tx_take | input | 1 | Channel accepts the offered byte |
| ch_tx_idle | input | 1 | Channel shifter is idle |
| ch_tx_data | output | CHAR_W | Byte offered for transmission |
| ch_tx_valid | output | 1 | A byte is offered |
| rx_enable | output | 1 | Receiver enable level |
| tx_enable | output | 1 | Transmitter enable level |
| rx_reset | output | 1 | One-cycle receiver reset pulse |
| tx_reset | output | 1 | One-cycle transmitter reset pulse |
| mode_out | output | MODE_W | Mode word for the channel |
| div_out | output | DIV_W | Baud divisor for the channel |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with MODE_W at 12, below the 32-bit bus width, so that a mode write with all ones shows the upper bits being dropped on readback. ADDR_W, DIV_W and CHAR_W keep their defaults of 8, 16 and 8. These defaults cover the full register map and the unmapped word at 0x24, and let a full byte check the receive and transmit data paths.

// File: rtl/sercom_pkg.sv
// Shared constants for the serial port register front end: word offsets,
// control command bit positions, status/interrupt bit positions and the
// set of interrupt bits that may be enabled.
package sercom_pkg;
    localparam int REG_W = 32;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_MODE  = 8'h04;
    localparam logic [7:0] OFF_IEN   = 8'h08;
    localparam logic [7:0] OFF_IDIS  = 8'h0C;
    localparam logic [7:0] OFF_IMASK = 8'h10;
    localparam logic [7:0] OFF_STAT  = 8'h14;
    localparam logic [7:0] OFF_RXH   = 8'h18;
    localparam logic [7:0] OFF_TXH   = 8'h1C;
    localparam logic [7:0] OFF_DIV   = 8'h20;

    localparam int CB_RXRST  = 2;
    localparam int CB_TXRST  = 3;
    localparam int CB_RXON   = 4;
    localparam int CB_RXOFF  = 5;
    localparam int CB_TXON   = 6;
    localparam int CB_TXOFF  = 7;
    localparam int CB_ERRCLR = 8;

    localparam int ST_RXRDY = 0;
    localparam int ST_TXRDY = 1;
    localparam int ST_OVR   = 5;
    localparam int ST_FRM   = 6;
    localparam int ST_PAR   = 7;
    localparam int ST_TXEMP = 9;

    localparam logic [REG_W-1:0] IRQ_BITS = 32'hC000_1AFB;
endpackage

// File: rtl/sercom_ctrl.sv
// Control command decoder. Turns a control-word write into enable levels
// for the receive and transmit directions and one-cycle reset and
// error-clear pulses. Assumes ctrl_wr is a single-cycle strobe.
// Disable or reset wins over enable within one write.
module sercom_ctrl
    import sercom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_bits,
    output logic             rx_en,
    output logic             tx_en,
    output logic             rx_rst,
    output logic             tx_rst,
    output logic             err_clr
);
    localparam int LANES = 2;

    logic [LANES-1:0] en_vec;
    logic [LANES-1:0] rst_vec;
    logic             unused_bits;

    generate
        for (genvar d = 0; d < LANES; d++) begin : g_lane
            localparam int ONB  = (d == 0) ? CB_RXON  : CB_TXON;
            localparam int OFFB = (d == 0) ? CB_RXOFF : CB_TXOFF;
            localparam int RSTB = (d == 0) ? CB_RXRST : CB_TXRST;

            logic en_r;

            // Enable level per direction, turning off has priority.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_r <= 1'b0;
                end else if (ctrl_wr) begin
                    if (ctrl_bits[OFFB] || ctrl_bits[RSTB]) begin
                        en_r <= 1'b0;
                    end else if (ctrl_bits[ONB]) begin
                        en_r <= 1'b1;
                    end
                end
            end

            assign en_vec[d]  = en_r;
            assign rst_vec[d] = ctrl_wr & ctrl_bits[RSTB];

            // R2
            off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_wr && ctrl_bits[OFFB]) |=> !en_r);
            // R2
            on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_wr && ctrl_bits[ONB] && !ctrl_bits[OFFB] && !ctrl_bits[RSTB]) |=> en_r);
            // R3
            rst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_wr && ctrl_bits[RSTB]) |=> !en_r);
        end
    endgenerate

    assign rx_en       = en_vec[0];
    assign tx_en       = en_vec[1];
    assign rx_rst      = rst_vec[0];
    assign tx_rst      = rst_vec[1];
    assign err_clr     = ctrl_wr & ctrl_bits[CB_ERRCLR];
    assign unused_bits = ^{ctrl_bits[REG_W-1:CB_ERRCLR+1], ctrl_bits[1:0]};
endmodule

// File: rtl/sercom_irq.sv
// Interrupt mask and request. The mask changes only through a set port
// (limited to the assigned bits) and a clear port. The request is the
// level OR of status bits that are also masked in. Assumes the set and
// clear strobes are never active together, since they decode from
// different addresses.
module sercom_irq
    import sercom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] status,
    output logic [REG_W-1:0] mask,
    output logic             irq
);
    // Mask update: set port OR-in, clear port AND-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (ien_wr) begin
            mask <= mask | (wdata & IRQ_BITS);
        end else if (idis_wr) begin
            mask <= mask & ~wdata;
        end
    end

    // Level request from masked status.
    assign irq = |(status & mask);

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idis_wr |=> ((mask & $past(wdata)) == '0));
    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_wr |=> ((mask & $past(wdata) & IRQ_BITS) == ($past(wdata) & IRQ_BITS)));
    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_wr && !idis_wr) |=> $stable(mask));
    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/sercom_hold.sv
// Holding registers and status flags. Stores bytes from the channel while
// the receiver is enabled and flags overrun and framing/parity errors.
// Holds one byte for transmission until the channel takes it. Assumes
// rx_read and tx_write are single-cycle strobes. A new event that sets an
// error flag wins over a clear command in the same cycle.
module sercom_hold
    import sercom_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              rx_rst,
    input  logic              tx_rst,
    input  logic              err_clr,
    input  logic              rx_read,
    input  logic              tx_write,
    input  logic [CHAR_W-1:0] tx_wdata,
    input  logic              ch_rx_valid,
    input  logic [CHAR_W-1:0] ch_rx_data,
    input  logic              ch_rx_frame_err,
    input  logic              ch_rx_parity_err,
    input  logic              ch_tx_take,
    input  logic              ch_tx_idle,
    output logic [CHAR_W-1:0] rx_data,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    output logic [REG_W-1:0]  status
);
    logic rx_take;
    logic rx_rdy, ovr, frm, par, tx_pend;

    assign rx_take  = ch_rx_valid & rx_en;
    assign tx_valid = tx_pend & tx_en;

    // Receive byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_data <= '0;
        else if (rx_take) rx_data <= ch_rx_data;
    end

    // Receive ready: set by a new byte, cleared by read or receiver reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rx_rdy <= 1'b0;
        else if (rx_take)            rx_rdy <= 1'b1;
        else if (rx_read || rx_rst)  rx_rdy <= 1'b0;
    end

    // Sticky error flags, cleared only by the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
            frm <= 1'b0;
            par <= 1'b0;
        end else begin
            if (rx_take && rx_rdy && !rx_read)   ovr <= 1'b1;
            else if (err_clr)                    ovr <= 1'b0;
            if (rx_take && ch_rx_frame_err)      frm <= 1'b1;
            else if (err_clr)                    frm <= 1'b0;
            if (rx_take && ch_rx_parity_err)     par <= 1'b1;
            else if (err_clr)                    par <= 1'b0;
        end
    end

    // Transmit holding byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_data <= '0;
        else if (tx_write) tx_data <= tx_wdata;
    end

    // Transmit pending: set by a write, cleared by channel take or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   tx_pend <= 1'b0;
        else if (tx_write)                            tx_pend <= 1'b1;
        else if (tx_rst || (ch_tx_take && tx_valid))  tx_pend <= 1'b0;
    end

    // Status word assembly.
    always_comb begin
        status           = '0;
        status[ST_RXRDY] = rx_rdy;
        status[ST_TXRDY] = !tx_pend;
        status[ST_OVR]   = ovr;
        status[ST_FRM]   = frm;
        status[ST_PAR]   = par;
        status[ST_TXEMP] = !tx_pend && ch_tx_idle;
    end

    // R7
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_take && rx_rdy && !rx_read) |=> ovr);
    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !rx_take) |=> !rx_rdy);
    // R6
    rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en) |=> $stable(rx_data));
    // R9
    tx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> !status[ST_TXRDY]);
    // R8
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !rx_take) |=> (!ovr && !frm && !par));
endmodule

// File: rtl/sercom_regs.sv
// Serial port register front end, top level. Decodes word-aligned bus
// accesses (full address compare, so misaligned addresses hit nothing),
// holds mode and divisor, and returns read data combinationally in the
// cycle of the read strobe. A read of the receive holding register clears
// receive ready at the following clock edge.
module sercom_regs
    import sercom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int MODE_W = 16,
    parameter int DIV_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ch_rx_valid,
    input  logic [CHAR_W-1:0] ch_rx_data,
    input  logic              ch_rx_frame_err,
    input  logic              ch_rx_parity_err,
    input  logic              ch_tx_take,
    input  logic              ch_tx_idle,
    output logic [CHAR_W-1:0] ch_tx_data,
    output logic              ch_tx_valid,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic              rx_reset,
    output logic              tx_reset,
    output logic [MODE_W-1:0] mode_out,
    output logic [DIV_W-1:0]  div_out,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFF_IEN);
    localparam logic [ADDR_W-1:0] A_IDIS  = ADDR_W'(OFF_IDIS);
    localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(OFF_IMASK);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_RXH   = ADDR_W'(OFF_RXH);
    localparam logic [ADDR_W-1:0] A_TXH   = ADDR_W'(OFF_TXH);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFF_DIV);

    logic             ctrl_wr, ien_wr, idis_wr, tx_write, rx_read;
    logic             err_clr;
    logic [REG_W-1:0] status, mask;
    logic [CHAR_W-1:0] rx_data;

    // Write and read strobe decode.
    assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
    assign ien_wr   = bus_wr && (bus_addr == A_IEN);
    assign idis_wr  = bus_wr && (bus_addr == A_IDIS);
    assign tx_write = bus_wr && (bus_addr == A_TXH);
    assign rx_read  = bus_rd && (bus_addr == A_RXH);

    // Mode and divisor storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_out <= '0;
            div_out  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MODE) mode_out <= bus_wdata[MODE_W-1:0];
            if (bus_addr == A_DIV)  div_out  <= bus_wdata[DIV_W-1:0];
        end
    end

    sercom_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (bus_wdata),
        .rx_en     (rx_enable),
        .tx_en     (tx_enable),
        .rx_rst    (rx_reset),
        .tx_rst    (tx_reset),
        .err_clr   (err_clr)
    );

    sercom_hold #(.CHAR_W(CHAR_W)) u_hold (
        .clk              (clk),
        .rst_n            (rst_n),
        .rx_en            (rx_enable),
        .tx_en            (tx_enable),
        .rx_rst           (rx_reset),
        .tx_rst           (tx_reset),
        .err_clr          (err_clr),
        .rx_read          (rx_read),
        .tx_write         (tx_write),
        .tx_wdata         (bus_wdata[CHAR_W-1:0]),
        .ch_rx_valid      (ch_rx_valid),
        .ch_rx_data       (ch_rx_data),
        .ch_rx_frame_err  (ch_rx_frame_err),
        .ch_rx_parity_err (ch_rx_parity_err),
        .ch_tx_take       (ch_tx_take),
        .ch_tx_idle       (ch_tx_idle),
        .rx_data          (rx_data),
        .tx_data          (ch_tx_data),
        .tx_valid         (ch_tx_valid),
        .status           (status)
    );

    sercom_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_wr  (ien_wr),
        .idis_wr (idis_wr),
        .wdata   (bus_wdata),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    // Read data multiplexer, zero for unmapped or write-only words.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_MODE:  bus_rdata = REG_W'(mode_out);
                A_IMASK: bus_rdata = mask;
                A_STAT:  bus_rdata = status;
                A_RXH:   bus_rdata = REG_W'(rx_data);
                A_DIV:   bus_rdata = REG_W'(div_out);
                default: bus_rdata = '0;
            endcase
        end
    end

    // R3
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> !rx_reset);
    // R9
    tx_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_tx_valid |-> tx_enable);
endmodule

// File: tb/sercom_regs_tb_top.sv
module sercom_regs_tb_top;
    localparam int MW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ch_rx_valid = 1'b0;
    logic [7:0]  ch_rx_data = '0;
    logic        ch_rx_frame_err = 1'b0, ch_rx_parity_err = 1'b0;
    logic        ch_tx_take = 1'b0, ch_tx_idle = 1'b1;
    logic [7:0]  ch_tx_data;
    logic        ch_tx_valid, rx_enable, tx_enable, rx_reset, tx_reset, irq;
    logic [MW-1:0] mode_out;
    logic [15:0] div_out;

    int n_chk = 0, n_err = 0;

    // bench model of the register state
    logic        m_rx_en = 0, m_tx_en = 0, m_rdy = 0, m_pend = 0;
    logic        m_ovr = 0, m_frm = 0, m_par = 0;
    logic [31:0] m_mask = 0;
    logic [7:0]  m_rxd = 0, m_txd = 0;

    sercom_regs #(.ADDR_W(8), .MODE_W(MW), .DIV_W(16), .CHAR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_rx_valid(ch_rx_valid), .ch_rx_data(ch_rx_data),
        .ch_rx_frame_err(ch_rx_frame_err), .ch_rx_parity_err(ch_rx_parity_err),
        .ch_tx_take(ch_tx_take), .ch_tx_idle(ch_tx_idle),
        .ch_tx_data(ch_tx_data), .ch_tx_valid(ch_tx_valid),
        .rx_enable(rx_enable), .tx_enable(tx_enable),
        .rx_reset(rx_reset), .tx_reset(tx_reset),
        .mode_out(mode_out), .div_out(div_out), .irq(irq));

    always #5 clk = ~clk;

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[0] = m_rdy;  s[1] = !m_pend; s[5] = m_ovr;
        s[6] = m_frm;  s[7] = m_par;   s[9] = !m_pend && ch_tx_idle;
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic do_ctrl(input logic [31:0] d);
        bus_write(8'h00, d);
        if (d[2] || d[5]) m_rx_en = 0; else if (d[4]) m_rx_en = 1;
        if (d[3] || d[7]) m_tx_en = 0; else if (d[6]) m_tx_en = 1;
        if (d[2]) m_rdy = 0;
        if (d[3]) m_pend = 0;
        if (d[8]) begin m_ovr = 0; m_frm = 0; m_par = 0; end
    endtask

    task automatic do_rx(input logic [7:0] b, input logic fe, input logic pe);
        ch_rx_valid = 1; ch_rx_data = b; ch_rx_frame_err = fe; ch_rx_parity_err = pe;
        @(negedge clk);
        ch_rx_valid = 0; ch_rx_frame_err = 0; ch_rx_parity_err = 0;
        if (m_rx_en) begin
            if (m_rdy) m_ovr = 1;
            m_rdy = 1; m_rxd = b;
            if (fe) m_frm = 1;
            if (pe) m_par = 1;
        end
    endtask

    task automatic do_take();
        ch_tx_take = 1;
        @(negedge clk);
        ch_tx_take = 0;
        if (m_pend && m_tx_en) m_pend = 0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        bus_read(8'h14, v);
        chk({tag, " R5/R10 status"}, v, exp_status());
        bus_read(8'h10, v);
        chk({tag, " R4 mask"}, v, m_mask);
        chk({tag, " R5 irq"}, {31'b0, irq}, {31'b0, |(exp_status() & m_mask)});
        chk({tag, " R2 enables"}, {30'b0, rx_enable, tx_enable}, {30'b0, m_rx_en, m_tx_en});
        chk({tag, " R9 tx offer"}, {31'b0, ch_tx_valid}, {31'b0, m_pend && m_tx_en});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h14, v);
        chk("R1 status after reset", v, 32'h0000_0202);
        chk("R1 irq/enables after reset", {29'b0, irq, rx_enable, tx_enable}, 32'h0);
        bus_read(8'h10, v);
        chk("R1 mask after reset", v, 32'h0);

        // R2 enable and disable in one write: disable wins
        do_ctrl(32'h30);
        chk("R2 rx on+off", {31'b0, rx_enable}, 32'h0);
        do_ctrl(32'hC0);
        chk("R2 tx on+off", {31'b0, tx_enable}, 32'h0);
        do_ctrl(32'h50);
        chk("R2 both on", {30'b0, rx_enable, tx_enable}, 32'h3);

        // R4 mask set limited to assigned bits, read-only view, clear port
        bus_write(8'h08, 32'hFFFF_FFFF); m_mask = 32'hC000_1AFB;
        bus_read(8'h10, v);
        chk("R4 mask set filtered", v, 32'hC000_1AFB);
        bus_write(8'h10, 32'h0);
        bus_read(8'h10, v);
        chk("R4 mask write ignored", v, 32'hC000_1AFB);
        bus_write(8'h0C, 32'hFFFF_FFFF); m_mask = 0;
        bus_read(8'h10, v);
        chk("R4 mask cleared", v, 32'h0);

        // R6 byte ignored while receiver off
        do_ctrl(32'h20);
        do_rx(8'hA5, 0, 0);
        bus_read(8'h18, v);
        chk("R6 rx disabled ignores byte", v, 32'h0);
        check_all("R6 off");

        // R6/R7 overrun: two bytes without read
        do_ctrl(32'h10);
        do_rx(8'h11, 0, 0);
        do_rx(8'h22, 0, 0);
        bus_read(8'h14, v);
        chk("R7 overrun flag", v & 32'h21, 32'h21);
        bus_read(8'h18, v); m_rdy = 0;
        chk("R7 newest byte kept", v, 32'h22);
        check_all("R6 read clears");

        // R8 error flags and clear command
        do_rx(8'h33, 1, 1);
        bus_read(8'h14, v);
        chk("R8 frame+parity set", v & 32'hE0, 32'hE0);
        do_ctrl(32'h100);
        bus_read(8'h14, v);
        chk("R8 clear command", v & 32'hE0, 32'h0);

        // R5 irq follows masked status
        bus_write(8'h08, 32'h1); m_mask = 32'h1;
        chk("R5 irq on rx ready", {31'b0, irq}, 32'h1);
        bus_read(8'h18, v); m_rdy = 0;
        chk("R5 irq drops after read", {31'b0, irq}, 32'h0);

        // R9/R10 transmit path
        bus_write(8'h1C, 32'h5A); m_pend = 1; m_txd = 8'h5A;
        chk("R9 offered byte", {24'b0, ch_tx_data}, 32'h5A);
        check_all("R9 pending");
        ch_tx_idle = 0;
        do_take();
        bus_read(8'h14, v);
        chk("R10 not empty while busy", v & 32'h202, 32'h002);
        ch_tx_idle = 1; #1;
        bus_read(8'h14, v);
        chk("R10 empty when idle", v & 32'h202, 32'h202);

        // R3 resets
        do_rx(8'h44, 0, 0);
        bus_write(8'h1C, 32'h77); m_pend = 1; m_txd = 8'h77;
        bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h0C; #1;
        chk("R3 reset pulses", {30'b0, rx_reset, tx_reset}, 32'h3);
        @(negedge clk); bus_wr = 0;
        m_rx_en = 0; m_tx_en = 0; m_rdy = 0; m_pend = 0;
        check_all("R3 after reset cmd");

        // R11 mode/divisor widths and unmapped reads
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, v);
        chk("R11 mode width", v, 32'h0000_0FFF);
        bus_write(8'h20, 32'h1234_ABCD);
        bus_read(8'h20, v);
        chk("R11 divisor", v, 32'h0000_ABCD);
        bus_read(8'h24, v);
        chk("R11 unmapped", v, 32'h0);
        bus_read(8'h1C, v);
        chk("R11 write-only word", v, 32'h0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            case ($urandom % 8)
                0: do_ctrl($urandom & 32'h1FC);
                1: begin v = $urandom; bus_write(8'h08, v); m_mask = m_mask | (v & 32'hC000_1AFB); end
                2: begin v = $urandom & $urandom; bus_write(8'h0C, v); m_mask = m_mask & ~v; end
                3: do_rx(8'($urandom), 1'($urandom % 5 == 0), 1'($urandom % 5 == 0));
                4: begin
                       bus_read(8'h18, v);
                       chk("R6 random rx read", v, {24'b0, m_rxd});
                       m_rdy = 0;
                   end
                5: begin v = $urandom; bus_write(8'h1C, v); m_pend = 1; m_txd = v[7:0]; end
                6: begin
                       if (ch_tx_valid) chk("R9 random tx byte", {24'b0, ch_tx_data}, {24'b0, m_txd});
                       do_take();
                   end
                default: begin ch_tx_idle = 1'($urandom); #1; end
            endcase
            if (i % 4 == 0) check_all("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule